// File: doc/BRIEF.md
# Selectable Cartridge Chip-Select Decoder

This block turns a console bus address into the active-low chip-select strobes of a cartridge: up to three ROM selects, one battery-RAM select, one spare select and a shared ROM output enable. Its inputs are the eight bank bits (address bits 23..16), the sixteen offset bits (15..0), the console's active-low ROM-select strobe, and reset. It is meant for a development cartridge that must behave like any of several production boards, so one decoder stands in for all of them.

A two-bit map-select input picks one of four board schemes. The choice is captured only while reset is held and cannot change afterwards. Each scheme has its own rule for which address bits are ignored and where open bus arises. Outputs are registered, so every strobe reflects the address sampled at the previous rising clock edge. A three-bit hit code on the outputs names the active select, so a test can compare whole memory maps.

Top module: `cart_sel_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge every select and the output enable are high and the hit code is 0. Out of reset, outputs show the decode of the inputs sampled at the previous rising edge.
- R2: `map_sel_i` is captured only at edges with `rst_n` low; changing it while out of reset has no effect on the decode.
- R3: Map 0 (three-ROM): with the ROM strobe low, bank bits 22..21 of 00 select ROM1, 01 select ROM2 and 10 select ROM3. Bank bit 23 and offset bit 15 do not affect the choice.
- R4: Map 0: with the ROM strobe low, bank bits 22..20 = 111 and offset bit 15 = 0 select RAM, and bank bits 22..20 = 110 with offset bit 15 = 0 select the spare. Other addresses in banks 60-7F/E0-FF are open bus.
- R5: Map 1 (gated reduced): bank groups 00 and 01 select ROM1 and ROM2, group 10 is open bus, and RAM needs bank bit 20 = 1 and offset bit 15 = 0, so offsets 8000-FFFF of those banks are open. The spare rule is the same as in R4.
- R6: Map 2 (full reduced): group 00 selects ROM1, groups 01 and 10 are open, and bank bit 20 = 1 in group 11 selects RAM at every offset. The spare rule is the same as in R4.
- R7: Map 3 (64 KB page): with the ROM strobe low, ROM1 is selected when bank bit 23 = 0, and the address is open bus when it is 1.
- R8: Map 3: with the ROM strobe high and offset bits 14..13 = 11, bank bits 22..21 = 01 select RAM and = 00 select the spare, whatever bank bit 23 is.
- R9: With the ROM strobe high, no ROM select or output enable asserts in any map, and maps 0-2 assert nothing at all.
- R10: At most one of the ROM, RAM and spare selects is low at once. The output enable is low exactly when a ROM select is low. The hit code is 0 none, 1 ROM1, 2 ROM2, 3 ROM3, 4 RAM, 5 spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; map is captured while low |
| map_sel_i | input | 2 | Board scheme: 0 three-ROM, 1 gated reduced, 2 full reduced, 3 64 KB page |
| bank_i | input | BANK_W | Address bits 23..16 |
| ofs_i | input | OFS_W | Address bits 15..0 |
| romsel_n_i | input | 1 | Console ROM-select strobe, active low |
| rom_cs_n_o | output | 3 | ROM chip selects, active low, bit k is ROM k+1 |
| ram_cs_n_o | output | 1 | Battery RAM select, active low |
| spare_cs_n_o | output | 1 | Spare select, active low |
| rom_oe_n_o | output | 1 | ROM output enable, active low |
| hit_o | output | 3 | Code of the active select |

## Verification
The bench builds the decoder with the default widths of an 8-bit bank and a 16-bit offset. These place bits 23, 22..20, 15 and 14..13 exactly where the board schemes look for them, so every bank group, mirror half and RAM window of all four maps can be reached by directed addresses. The run resets into each map in turn. For each map it probes the ignored bits, the open-bus holes and the inactive ROM strobe, and it changes the map input mid-run to show the captured scheme holds.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

    localparam int ROM_COUNT = 3;
    localparam int HIT_W     = 3;

    typedef enum logic [1:0] {
        MAP_TRIPLE   = 2'd0,
        MAP_LO_GATED = 2'd1,
        MAP_LO_FULL  = 2'd2,
        MAP_PAGE64   = 2'd3
    } map_e;

    typedef enum logic [HIT_W-1:0] {
        HIT_NONE  = 3'd0,
        HIT_ROM1  = 3'd1,
        HIT_ROM2  = 3'd2,
        HIT_ROM3  = 3'd3,
        HIT_RAM   = 3'd4,
        HIT_SPARE = 3'd5
    } hit_e;

    typedef struct packed {
        map_e map;
        hit_e hit;
    } dec_state_t;

endpackage

// File: rtl/cdec_lo32.sv
module cdec_lo32
    import cdec_pkg::*;
(
    input  map_e       map_i,
    input  logic [1:0] group_i,
    input  logic       a20_i,
    input  logic       a15_i,
    input  logic       romsel_n_i,
    output hit_e       hit_o
);

    hit_e rom_hit;
    hit_e top_hit;

    always_comb begin
        rom_hit = HIT_NONE;
        unique case (group_i)
            2'b00: rom_hit = HIT_ROM1;
            2'b01: rom_hit = (map_i == MAP_LO_FULL) ? HIT_NONE : HIT_ROM2;
            2'b10: rom_hit = (map_i == MAP_TRIPLE)  ? HIT_ROM3 : HIT_NONE;
            default: rom_hit = HIT_NONE;
        endcase
    end

    always_comb begin
        top_hit = HIT_NONE;
        if (a20_i) begin
            if (map_i == MAP_LO_FULL || !a15_i)
                top_hit = HIT_RAM;
        end else if (!a15_i) begin
            top_hit = HIT_SPARE;
        end
    end

    always_comb begin
        if (romsel_n_i)
            hit_o = HIT_NONE;
        else if (group_i == 2'b11)
            hit_o = top_hit;
        else
            hit_o = rom_hit;
    end

endmodule

// File: rtl/cdec_page64.sv
module cdec_page64
    import cdec_pkg::*;
(
    input  logic       b23_i,
    input  logic [1:0] group_i,
    input  logic [1:0] win_i,
    input  logic       romsel_n_i,
    output hit_e       hit_o
);

    logic in_window;

    assign in_window = (win_i == 2'b11);

    always_comb begin
        hit_o = HIT_NONE;
        if (!romsel_n_i) begin
            if (!b23_i)
                hit_o = HIT_ROM1;
        end else if (in_window) begin
            unique case (group_i)
                2'b01:   hit_o = HIT_RAM;
                2'b00:   hit_o = HIT_SPARE;
                default: hit_o = HIT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cdec_strobe.sv
module cdec_strobe
    import cdec_pkg::*;
#(
    parameter int NUM_ROM = ROM_COUNT
) (
    input  hit_e               hit_i,
    output logic [NUM_ROM-1:0] rom_cs_n_o,
    output logic               ram_cs_n_o,
    output logic               spare_cs_n_o,
    output logic               rom_oe_n_o
);

    logic [HIT_W-1:0] code;

    assign code = hit_i;

    for (genvar k = 0; k < NUM_ROM; k++) begin : g_rom
        assign rom_cs_n_o[k] = (code != HIT_W'(k + 1));
    end

    assign ram_cs_n_o   = (hit_i != HIT_RAM);
    assign spare_cs_n_o = (hit_i != HIT_SPARE);
    assign rom_oe_n_o   = &rom_cs_n_o;

endmodule

// File: rtl/cart_sel_decoder.sv
module cart_sel_decoder
    import cdec_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           map_sel_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [OFS_W-1:0]     ofs_i,
    input  logic                 romsel_n_i,
    output logic [ROM_COUNT-1:0] rom_cs_n_o,
    output logic                 ram_cs_n_o,
    output logic                 spare_cs_n_o,
    output logic                 rom_oe_n_o,
    output logic [HIT_W-1:0]     hit_o
);

    localparam int B23 = BANK_W - 1;
    localparam int B22 = BANK_W - 2;
    localparam int B20 = BANK_W - 4;
    localparam int A15 = OFS_W - 1;
    localparam int A14 = OFS_W - 2;

    dec_state_t state_d;
    dec_state_t state_q;
    hit_e       hit_lo;
    hit_e       hit_hi;
    map_e       map_q;
    logic       unused_bits;

    assign unused_bits = ^{bank_i[B20-1:0], ofs_i[A14-2:0]};
    assign map_q       = state_q.map;

    cdec_lo32 u_lo32 (
        .map_i      (state_q.map),
        .group_i    (bank_i[B22 -: 2]),
        .a20_i      (bank_i[B20]),
        .a15_i      (ofs_i[A15]),
        .romsel_n_i (romsel_n_i),
        .hit_o      (hit_lo)
    );

    cdec_page64 u_page64 (
        .b23_i      (bank_i[B23]),
        .group_i    (bank_i[B22 -: 2]),
        .win_i      (ofs_i[A14 -: 2]),
        .romsel_n_i (romsel_n_i),
        .hit_o      (hit_hi)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.map = map_e'(map_sel_i);
            state_d.hit = HIT_NONE;
        end else if (state_q.map == MAP_PAGE64) begin
            state_d.hit = hit_hi;
        end else begin
            state_d.hit = hit_lo;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    cdec_strobe #(.NUM_ROM(ROM_COUNT)) u_strobe (
        .hit_i        (state_q.hit),
        .rom_cs_n_o   (rom_cs_n_o),
        .ram_cs_n_o   (ram_cs_n_o),
        .spare_cs_n_o (spare_cs_n_o),
        .rom_oe_n_o   (rom_oe_n_o)
    );

    assign hit_o = state_q.hit;

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker
    import cdec_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input map_e                 map_q,
    input logic [7:0]           bank_i,
    input logic [15:0]          ofs_i,
    input logic                 romsel_n_i,
    input logic [ROM_COUNT-1:0] rom_cs_n_o,
    input logic                 ram_cs_n_o,
    input logic                 spare_cs_n_o,
    input logic                 rom_oe_n_o
);

    logic [ROM_COUNT+1:0] active;

    assign active = ~{rom_cs_n_o, ram_cs_n_o, spare_cs_n_o};

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (&rom_cs_n_o && ram_cs_n_o && spare_cs_n_o && rom_oe_n_o));

    p_map_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(map_q));

    p_page64_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q == MAP_PAGE64 && romsel_n_i && bank_i[6:5] == 2'b01 && ofs_i[14:13] == 2'b11)
        |=> !ram_cs_n_o);

    p_no_rom_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        romsel_n_i |=> (&rom_cs_n_o && rom_oe_n_o));

    p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(active) <= 1);

    p_oe_follows_rom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rom_oe_n_o == &rom_cs_n_o));

endmodule

bind cart_sel_decoder cdec_checker u_cdec_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .map_q        (map_q),
    .bank_i       (bank_i),
    .ofs_i        (ofs_i),
    .romsel_n_i   (romsel_n_i),
    .rom_cs_n_o   (rom_cs_n_o),
    .ram_cs_n_o   (ram_cs_n_o),
    .spare_cs_n_o (spare_cs_n_o),
    .rom_oe_n_o   (rom_oe_n_o)
);

// File: tb/test_cart_sel_decoder.sv
module test_cart_sel_decoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] map_sel_i = 2'd0;
    logic [7:0] bank_i = 8'h00;
    logic [15:0] ofs_i = 16'h0000;
    logic       romsel_n_i = 1'b1;
    logic [2:0] rom_cs_n_o;
    logic       ram_cs_n_o;
    logic       spare_cs_n_o;
    logic       rom_oe_n_o;
    logic [2:0] hit_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_sel_decoder i_cart_sel_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .map_sel_i    (map_sel_i),
        .bank_i       (bank_i),
        .ofs_i        (ofs_i),
        .romsel_n_i   (romsel_n_i),
        .rom_cs_n_o   (rom_cs_n_o),
        .ram_cs_n_o   (ram_cs_n_o),
        .spare_cs_n_o (spare_cs_n_o),
        .rom_oe_n_o   (rom_oe_n_o),
        .hit_o        (hit_o)
    );

    // Expected pins from a hit code (R10 encoding).
    function automatic logic [8:0] pins_for(input int code);
        logic [2:0] rom;
        rom[0] = (code != 1);
        rom[1] = (code != 2);
        rom[2] = (code != 3);
        return {rom, logic'(code != 4), logic'(code != 5),
                logic'(!(code >= 1 && code <= 3)), 3'(code)};
    endfunction

    task automatic compare(input int code, input string tag);
        logic [8:0] got;
        logic [8:0] exp;
        got = {rom_cs_n_o, ram_cs_n_o, spare_cs_n_o, rom_oe_n_o, hit_o};
        exp = pins_for(code);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s bank=%h ofs=%h romsel_n=%b actual=%b expected=%b",
                     tag, bank_i, ofs_i, romsel_n_i, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] b, input logic [15:0] o,
                         input logic rs, input int code, input string tag);
        @(negedge clk);
        bank_i = b;
        ofs_i = o;
        romsel_n_i = rs;
        @(negedge clk);
        compare(code, tag);
    endtask

    task automatic reset_into(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        map_sel_i = m;
        bank_i = 8'h00;
        ofs_i = 16'h8000;
        romsel_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare(0, "R1 held reset");
        rst_n = 1'b1;
    endtask

    task automatic t_triple;
        reset_into(2'd0);
        apply(8'h00, 16'h8000, 1'b0, 1, "R3 rom1");
        apply(8'h9F, 16'h8123, 1'b0, 1, "R3 rom1 b23 ignored");
        apply(8'h20, 16'hFFFF, 1'b0, 2, "R3 rom2");
        apply(8'h45, 16'h0000, 1'b0, 3, "R3 rom3 low half");
        apply(8'hC5, 16'h8000, 1'b0, 3, "R3 rom3 b23 ignored");
        apply(8'h72, 16'h0000, 1'b0, 4, "R4 ram");
        apply(8'hF0, 16'h7FFF, 1'b0, 4, "R4 ram mirror");
        apply(8'h72, 16'h8000, 1'b0, 0, "R4 open upper");
        apply(8'h65, 16'h1000, 1'b0, 5, "R4 spare");
        apply(8'h65, 16'h9000, 1'b0, 0, "R4 spare upper open");
    endtask

    task automatic t_lo_gated;
        reset_into(2'd1);
        apply(8'h10, 16'h8000, 1'b0, 1, "R5 rom1");
        apply(8'h30, 16'h8000, 1'b0, 2, "R5 rom2");
        apply(8'h50, 16'h0000, 1'b0, 0, "R5 group2 open");
        apply(8'h7D, 16'h0000, 1'b0, 4, "R5 ram");
        apply(8'h7D, 16'h8000, 1'b0, 0, "R5 ram upper open");
        apply(8'hE5, 16'h0000, 1'b0, 5, "R5 spare");
    endtask

    task automatic t_lo_full;
        reset_into(2'd2);
        apply(8'h00, 16'h8000, 1'b0, 1, "R6 rom1");
        apply(8'h30, 16'h8000, 1'b0, 0, "R6 group1 open");
        apply(8'h50, 16'h8000, 1'b0, 0, "R6 group2 open");
        apply(8'hF3, 16'hC000, 1'b0, 4, "R6 ram upper");
        apply(8'h70, 16'h0000, 1'b0, 4, "R6 ram lower");
        apply(8'h60, 16'h0000, 1'b0, 5, "R6 spare");
    endtask

    task automatic t_page64;
        reset_into(2'd3);
        apply(8'h00, 16'h8000, 1'b0, 1, "R7 rom");
        apply(8'h45, 16'h0000, 1'b0, 1, "R7 rom full bank");
        apply(8'h85, 16'h0000, 1'b0, 0, "R7 b23 open");
        apply(8'h20, 16'h6000, 1'b1, 4, "R8 ram");
        apply(8'hA3, 16'h7FFF, 1'b1, 4, "R8 ram b23 ignored");
        apply(8'h00, 16'h6000, 1'b1, 5, "R8 spare");
        apply(8'h80, 16'h7000, 1'b1, 5, "R8 spare b23 ignored");
        apply(8'h40, 16'h6000, 1'b1, 0, "R8 group2 open");
        apply(8'h20, 16'h4000, 1'b1, 0, "R8 outside window");
        apply(8'h00, 16'h8000, 1'b1, 0, "R9 page64 idle");
    endtask

    task automatic t_idle;
        reset_into(2'd0);
        apply(8'h00, 16'h8000, 1'b1, 0, "R9 map0 rom idle");
        apply(8'h72, 16'h0000, 1'b1, 0, "R9 map0 ram idle");
        reset_into(2'd2);
        apply(8'h70, 16'h0000, 1'b1, 0, "R9 map2 ram idle");
    endtask

    task automatic t_map_lock;
        reset_into(2'd0);
        @(negedge clk);
        map_sel_i = 2'd3;
        apply(8'h45, 16'h0000, 1'b0, 3, "R2 map held rom3");
        apply(8'h20, 16'h6000, 1'b1, 0, "R2 map held no page64 ram");
        map_sel_i = 2'd2;
        apply(8'h20, 16'h8000, 1'b0, 2, "R2 map held rom2");
    endtask

    task automatic t_reset_mid;
        reset_into(2'd0);
        apply(8'h00, 16'h8000, 1'b0, 1, "R1 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare(0, "R1 reset mid run");
        rst_n = 1'b1;
        @(negedge clk);
        compare(1, "R1 one cycle latency after release");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_triple();
        t_lo_gated();
        t_lo_full();
        t_page64();
        t_idle();
        t_map_lock();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule